// File: doc/BRIEF.md
# Timer Channel: Compare, Capture and PWM

This block is one channel of a general-purpose timer. A shared counter outside the block supplies its current value. It also supplies a counter-advance strobe, a count-down indication and a strobe that marks the start of a period. The channel holds its own channel value register. A 2-bit mode field and a 2-bit selector field program what the channel does. From the counter and the channel value, the channel can generate an edge-aligned or centre-aligned PWM waveform with a chosen polarity. It can also act on a compare match, by changing the pin or by emitting a one-count pulse. As a third use, it can latch the counter value when a chosen edge arrives on an asynchronous input pin.

A compare match or a capture event raises a channel flag. Software clears the flag by pulsing a clear input. The channel value can be written directly. In capture mode the channel value is also read back, since the captured counter value lands there. The output pin, the flag and the channel value all come from registers.

Mode/selector encoding (selector 00 disables the channel in every mode):
mode 00 capture: 01 rising, 10 falling, 11 both edges.
mode 01 compare: 01 toggle, 10 clear, 11 set.
mode 10 PWM: 01 high-true, 10 low-true, 11 pin held low.
mode 11 pulse: 01 high pulse, 10 low pulse, 11 flag only with no pin change.

Top module: `tmr_chan_unit`

## Requirements
- R1: With selector 00 the channel is disabled in every mode. The pin is driven low one clock later, and no match or input edge sets the flag.
- R2: Edge-aligned PWM (`align_center`=0) uses the selector codes of R4. On a counter-advance cycle, a match drives the pin inactive, and otherwise the period strobe drives it active. The pin updates one clock after that cycle. A channel value of 0 keeps the pin inactive for the whole period. A value above the largest count keeps it active for the whole period.
- R3: In centre-aligned PWM (`align_center`=1), each advance makes the pin active when the counter is below the channel value and inactive otherwise, in both counting directions. Only a match while counting up (`cnt_down`=0) sets the flag.
- R4: PWM selector 01 makes the active level high. Selector 10 makes it low. Selector 11 holds the pin low, and matches still set the flag.
- R5: In compare mode (01), a match toggles the pin (selector 01), clears it (10) or sets it (11). Pulse mode with selector 11 sets the flag and leaves the pin unchanged.
- R6: Pulse mode (11) drives the pin to its active level (selector 01 high, selector 10 low) for exactly one counter advance after a match. On the next advance without a match, the pin returns to the idle level (low for 01, high for 10).
- R7: Capture mode (00) latches `cnt_val` into the channel value on the chosen edge of `cap_pin`. Selector 01 uses rising edges, 10 falling edges and 11 both edges. Edges that were not chosen leave the channel value and the flag unchanged.
- R8: `cap_pin` passes through a two-flop synchroniser. A transition made before clock edge k shows up in the flag and the channel value after clock edge k+2, and not earlier.
- R9: A match counts only on a cycle with `cnt_tick`=1 and `cnt_val` equal to the channel value. A match or a capture sets `chan_flag` on the next clock, and the flag holds until it is cleared.
- R10: `flag_clr`=1 clears the flag on the next clock. If a set event falls in the same cycle, the flag stays 1.
- R11: `val_wr`=1 loads `val_wdata` into the channel value on the next clock. A capture in the same cycle takes precedence over the write.
- R12: After a synchronous reset, `pin_out`, `chan_flag` and `chan_val` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Counter advances this cycle; `cnt_val` is valid for matching |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | Counter is counting down |
| cnt_wrap | input | 1 | Period start (counter at its first value) |
| align_center | input | 1 | PWM alignment: 0 edge, 1 centre |
| cfg_mode | input | 2 | Mode field |
| cfg_sel | input | 2 | Edge/level selector field |
| val_wr | input | 1 | Write strobe for the channel value |
| val_wdata | input | CNT_W | Channel value write data |
| flag_clr | input | 1 | Clear strobe for the channel flag |
| cap_pin | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Channel output pin |
| chan_val | output | CNT_W | Channel value register |
| chan_flag | output | 1 | Channel event flag |

## Verification
The bench drives edge-aligned PWM with a channel value of 0 and with a value above the period. A design that lets the period strobe beat the match would leak a one-count glitch at 0 % duty. The bench runs a centre-aligned pass down through the match value. A design that flags in both directions would raise the flag twice per period. The bench samples the capture flag one cycle early and at the expected cycle, which catches a missing or extra synchroniser stage. It also places a set and a clear in the same cycle, and a capture and a write in the same cycle. A design with the priorities reversed would lose the event.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'b00,
    MODE_COMPARE = 2'b01,
    MODE_PWM     = 2'b10,
    MODE_PULSE   = 2'b11
  } chan_mode_e;

  typedef enum logic [3:0] {
    K_OFF, K_CAP_RISE, K_CAP_FALL, K_CAP_BOTH,
    K_CMP_TOGGLE, K_CMP_CLEAR, K_CMP_SET, K_CMP_QUIET,
    K_PWM_HIGH, K_PWM_LOW, K_PWM_MUTE,
    K_PULSE_HIGH, K_PULSE_LOW
  } chan_kind_e;

  function automatic chan_kind_e decode_kind(input logic [1:0] mode, input logic [1:0] sel);
    chan_kind_e k;
    k = K_OFF;
    if (sel != 2'b00) begin
      case (chan_mode_e'(mode))
        MODE_CAPTURE: k = (sel == 2'b01) ? K_CAP_RISE   : (sel == 2'b10) ? K_CAP_FALL   : K_CAP_BOTH;
        MODE_COMPARE: k = (sel == 2'b01) ? K_CMP_TOGGLE : (sel == 2'b10) ? K_CMP_CLEAR  : K_CMP_SET;
        MODE_PWM:     k = (sel == 2'b01) ? K_PWM_HIGH   : (sel == 2'b10) ? K_PWM_LOW    : K_PWM_MUTE;
        default:      k = (sel == 2'b01) ? K_PULSE_HIGH : (sel == 2'b10) ? K_PULSE_LOW  : K_CMP_QUIET;
      endcase
    end
    return k;
  endfunction

  function automatic logic kind_matches(input chan_kind_e k);
    return k inside {K_CMP_TOGGLE, K_CMP_CLEAR, K_CMP_SET, K_CMP_QUIET,
                     K_PWM_HIGH, K_PWM_LOW, K_PWM_MUTE, K_PULSE_HIGH, K_PULSE_LOW};
  endfunction

  function automatic logic kind_is_pwm(input chan_kind_e k);
    return k inside {K_PWM_HIGH, K_PWM_LOW, K_PWM_MUTE};
  endfunction

endpackage

// File: rtl/tmr_chan_capsync.sv
module tmr_chan_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic arm_rise,
  input  logic arm_fall,
  output logic evt_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[TOP-1:0], pin_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[TOP];
  end

  always_comb begin
    evt_o = (arm_rise & sync_q[TOP] & ~prev_q) | (arm_fall & ~sync_q[TOP] & prev_q);
  end
endmodule

// File: rtl/tmr_chan_match.sv
module tmr_chan_match
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             align_center,
  input  logic [CNT_W-1:0] ref_val,
  input  chan_kind_e       kind,
  output logic             hit_o,
  output logic             below_o,
  output logic             match_evt_o
);
  logic center_down;

  always_comb begin
    hit_o       = cnt_tick & (cnt_val == ref_val);
    below_o     = cnt_val < ref_val;
    center_down = kind_is_pwm(kind) & align_center & cnt_down;
    match_evt_o = hit_o & kind_matches(kind) & ~center_down;
  end
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/tmr_chan_unit.sv
module tmr_chan_unit
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             cnt_wrap,
  input  logic             align_center,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_sel,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             flag_clr,
  input  logic             cap_pin,
  output logic             pin_out,
  output logic [CNT_W-1:0] chan_val,
  output logic             chan_flag
);
  chan_kind_e kind;
  logic       hit, below, match_evt, cap_evt, pwm_inv;

  always_comb begin
    kind    = decode_kind(cfg_mode, cfg_sel);
    pwm_inv = (kind == K_PWM_LOW);
  end

  tmr_chan_capsync #(.STAGES(SYNC_STAGES)) u_capsync (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (cap_pin),
    .arm_rise (kind == K_CAP_RISE || kind == K_CAP_BOTH),
    .arm_fall (kind == K_CAP_FALL || kind == K_CAP_BOTH),
    .evt_o    (cap_evt)
  );

  tmr_chan_match #(.CNT_W(CNT_W)) u_match (
    .cnt_tick     (cnt_tick),
    .cnt_val      (cnt_val),
    .cnt_down     (cnt_down),
    .align_center (align_center),
    .ref_val      (chan_val),
    .kind         (kind),
    .hit_o        (hit),
    .below_o      (below),
    .match_evt_o  (match_evt)
  );

  tmr_chan_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (match_evt | cap_evt),
    .clr_i  (flag_clr),
    .flag_o (chan_flag)
  );

  // channel value: capture beats a software write
  always_ff @(posedge clk) begin
    if (rst)          chan_val <= '0;
    else if (cap_evt) chan_val <= cnt_val;
    else if (val_wr)  chan_val <= val_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
    end else begin
      case (kind)
        K_CMP_TOGGLE: if (hit) pin_out <= ~pin_out;
        K_CMP_CLEAR:  if (hit) pin_out <= 1'b0;
        K_CMP_SET:    if (hit) pin_out <= 1'b1;
        K_CMP_QUIET:  pin_out <= pin_out;
        K_PWM_HIGH, K_PWM_LOW: begin
          if (cnt_tick) begin
            if (align_center)  pin_out <= below ^ pwm_inv;
            else if (hit)      pin_out <= pwm_inv;
            else if (cnt_wrap) pin_out <= ~pwm_inv;
          end
        end
        K_PULSE_HIGH: if (cnt_tick) pin_out <= hit;
        K_PULSE_LOW:  if (cnt_tick) pin_out <= ~hit;
        default:      pin_out <= 1'b0;
      endcase
    end
  end

  assert_off_low_R1: assert property (@(posedge clk) disable iff (rst)
    (kind == K_OFF) |=> !pin_out);
  assert_zero_duty_R2: assert property (@(posedge clk) disable iff (rst)
    (kind == K_PWM_HIGH && !align_center && hit) |=> !pin_out);
  assert_pulse_return_R6: assert property (@(posedge clk) disable iff (rst)
    (kind == K_PULSE_HIGH && cnt_tick && !hit) |=> !pin_out);
  assert_capture_latch_R7: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (chan_val == $past(cnt_val)));
endmodule

// File: tb/tmr_chan_unit_tb.sv
`timescale 1ns/1ps
module tmr_chan_unit_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_tick = 0, cnt_down = 0, cnt_wrap = 0, align_center = 0;
  logic [W-1:0] cnt_val = '0, val_wdata = '0;
  logic [1:0] cfg_mode = 2'b00, cfg_sel = 2'b00;
  logic val_wr = 0, flag_clr = 0, cap_pin = 0;
  logic pin_out, chan_flag;
  logic [W-1:0] chan_val;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_chan_unit #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .cnt_wrap(cnt_wrap), .align_center(align_center), .cfg_mode(cfg_mode), .cfg_sel(cfg_sel),
    .val_wr(val_wr), .val_wdata(val_wdata), .flag_clr(flag_clr), .cap_pin(cap_pin),
    .pin_out(pin_out), .chan_val(chan_val), .chan_flag(chan_flag));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [W-1:0] c, input bit wrap, input bit down, input bit tick);
    cnt_val = c; cnt_wrap = wrap; cnt_down = down; cnt_tick = tick;
    @(negedge clk);
    cnt_wrap = 0; cnt_tick = 0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] s, input bit ctr);
    cfg_mode = m; cfg_sel = s; align_center = ctr;
  endtask

  task automatic write_val(input logic [W-1:0] v);
    val_wr = 1; val_wdata = v; @(negedge clk); val_wr = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R12 pin after reset", pin_out, 0);
    chk("R12 flag after reset", chan_flag, 0);
    chk("R12 value after reset", chan_val, 0);
    write_val(16'h0005);
    chk("R11 software write", chan_val, 16'h0005);
  endtask

  task automatic t_edge_pwm(input logic [W-1:0] v, input bit high, input string tag);
    setup(2'b10, high ? 2'b01 : 2'b10, 0);
    write_val(v);
    clear_flag();
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= 7; c++) begin
        step(c[W-1:0], c == 0, 0, 1);
        chk(tag, pin_out, (c < v) ? high : !high);
      end
    chk("R9 flag after edge pwm", chan_flag, (v <= 7) ? 1 : 0);
  endtask

  task automatic t_mute();
    setup(2'b10, 2'b11, 0);
    write_val(3);
    clear_flag();
    for (int c = 0; c <= 7; c++) begin
      step(c[W-1:0], c == 0, 0, 1);
      chk("R4 muted pwm pin", pin_out, 0);
    end
    chk("R4 muted pwm still flags", chan_flag, 1);
  endtask

  task automatic t_center();
    setup(2'b10, 2'b01, 1);
    write_val(3);
    clear_flag();
    for (int c = 0; c <= 5; c++) begin
      step(c[W-1:0], c == 0, 0, 1);
      chk("R3 centre up pin", pin_out, c < 3);
    end
    chk("R3 flag on up match", chan_flag, 1);
    clear_flag();
    for (int c = 4; c >= 1; c--) begin
      step(c[W-1:0], 0, 1, 1);
      chk("R3 centre down pin", pin_out, c < 3);
    end
    chk("R3 no flag on down match", chan_flag, 0);
    cnt_down = 0;
  endtask

  task automatic t_compare();
    write_val(4);
    setup(2'b01, 2'b10, 0);
    for (int c = 0; c <= 6; c++) step(c[W-1:0], 0, 0, 1);
    chk("R5 clear on match", pin_out, 0);
    setup(2'b01, 2'b11, 0);
    clear_flag();
    for (int c = 0; c <= 6; c++) begin
      step(c[W-1:0], 0, 0, 1);
      chk("R5 set on match", pin_out, c >= 4);
      chk("R9 flag at match", chan_flag, c >= 4);
    end
    setup(2'b01, 2'b01, 0);
    for (int c = 0; c <= 6; c++) step(c[W-1:0], 0, 0, 1);
    chk("R5 toggle first", pin_out, 0);
    for (int c = 0; c <= 6; c++) step(c[W-1:0], 0, 0, 1);
    chk("R5 toggle second", pin_out, 1);
    setup(2'b11, 2'b11, 0);
    clear_flag();
    for (int c = 0; c <= 6; c++) step(c[W-1:0], 0, 0, 1);
    chk("R5 flag-only pin held", pin_out, 1);
    chk("R5 flag-only sets flag", chan_flag, 1);
  endtask

  task automatic t_pulse();
    write_val(2);
    setup(2'b11, 2'b01, 0);
    for (int c = 0; c <= 5; c++) begin
      step(c[W-1:0], 0, 0, 1);
      chk("R6 high pulse", pin_out, c == 2);
    end
    setup(2'b11, 2'b10, 0);
    for (int c = 0; c <= 5; c++) begin
      step(c[W-1:0], 0, 0, 1);
      chk("R6 low pulse", pin_out, c != 2);
    end
    setup(2'b11, 2'b01, 0);
    step(1, 0, 0, 1);
    clear_flag();
    step(2, 0, 0, 0);
    chk("R9 no match without tick", chan_flag, 0);
    chk("R9 no pulse without tick", pin_out, 0);
    step(2, 0, 0, 1);
    chk("R6 pulse starts", pin_out, 1);
    step(2, 0, 0, 0);
    chk("R6 pulse spans idle clock", pin_out, 1);
    step(3, 0, 0, 1);
    chk("R6 pulse ends next advance", pin_out, 0);
  endtask

  task automatic t_capture();
    setup(2'b00, 2'b01, 0);
    cap_pin = 0; repeat (4) step(16'h0100, 0, 0, 0);
    clear_flag();
    cnt_val = 16'h0111; cap_pin = 1;
    @(negedge clk); chk("R8 no flag after 1 clock", chan_flag, 0);
    @(negedge clk); chk("R8 no flag after 2 clocks", chan_flag, 0);
    @(negedge clk); chk("R8 flag after 3 clocks", chan_flag, 1);
    chk("R7 rising capture value", chan_val, 16'h0111);
    clear_flag();
    cnt_val = 16'h0222; cap_pin = 0; repeat (5) @(negedge clk);
    chk("R7 falling ignored in rise mode", chan_flag, 0);
    chk("R7 value kept", chan_val, 16'h0111);
    setup(2'b00, 2'b10, 0);
    cap_pin = 1; repeat (5) @(negedge clk);
    chk("R7 rising ignored in fall mode", chan_flag, 0);
    cnt_val = 16'h0333; cap_pin = 0; repeat (5) @(negedge clk);
    chk("R7 falling capture", chan_val, 16'h0333);
    setup(2'b00, 2'b11, 0);
    clear_flag();
    cnt_val = 16'h0444; cap_pin = 1; repeat (5) @(negedge clk);
    chk("R7 both edges rise", chan_val, 16'h0444);
    cnt_val = 16'h0555; cap_pin = 0; repeat (5) @(negedge clk);
    chk("R7 both edges fall", chan_val, 16'h0555);
    setup(2'b00, 2'b01, 0);
    cnt_val = 16'h0666; cap_pin = 1;
    @(negedge clk); @(negedge clk);
    val_wr = 1; val_wdata = 16'h0ABC;
    @(negedge clk); val_wr = 0;
    chk("R11 capture beats write", chan_val, 16'h0666);
  endtask

  task automatic t_disabled();
    write_val(2);
    setup(2'b01, 2'b00, 0);
    clear_flag();
    for (int c = 0; c <= 4; c++) step(c[W-1:0], 0, 0, 1);
    chk("R1 disabled pin", pin_out, 0);
    chk("R1 disabled no match flag", chan_flag, 0);
    setup(2'b00, 2'b00, 0);
    cap_pin = 0; repeat (5) @(negedge clk);
    cap_pin = 1; repeat (5) @(negedge clk);
    chk("R1 disabled no capture flag", chan_flag, 0);
    chk("R1 disabled value kept", chan_val, 2);
  endtask

  task automatic t_flag_prio();
    write_val(4);
    setup(2'b01, 2'b11, 0);
    clear_flag();
    flag_clr = 1;
    step(4, 0, 0, 1);
    flag_clr = 0;
    chk("R10 set wins over clear", chan_flag, 1);
    clear_flag();
    chk("R10 clear alone", chan_flag, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_edge_pwm(3, 1, "R2 edge pwm high-true duty 3");
    t_edge_pwm(0, 1, "R2 edge pwm zero duty");
    t_edge_pwm(9, 1, "R2 edge pwm full duty");
    t_edge_pwm(3, 0, "R4 edge pwm low-true");
    t_mute();
    t_center();
    t_compare();
    t_pulse();
    t_capture();
    t_disabled();
    t_flag_prio();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule